// File: doc/BRIEF.md
# Two-Channel Sample Averager and Output Coder

This block conditions a stream of signed two-channel converter samples before they reach a serial output stage. Each accepted input beat carries one word for channel A and one for channel B. Before any time averaging, the two channels can be merged into their rounded mean. The block then applies one of two time-averaging filters to each channel. The first is a decimating block average over 2 to 128 samples, which yields one output beat per completed block. The second is a sliding-window average over 2, 4 or 8 samples, which yields one output beat for every input once its window has filled. With neither filter active the samples pass through unchanged. The last stage recodes each word, either to offset binary or left as two's complement, and can scramble it with an XOR keyed on its own least significant bit.

Both data edges are valid/ready streams. An input beat is accepted in a cycle where `s_valid` and `s_ready` are both high. `s_ready` is high whenever the single output register is empty or is being drained in that cycle. An output beat stays stable on `m_cha`/`m_chb` while `m_valid` is high and `m_ready` is low. The configuration pins are plain levels and are sampled every cycle. The exception is `cfg_blk_sync`, which is a one-cycle pulse.

Top module: `samp_cond`

## Requirements
- R1: After reset `m_valid` is 0 and `s_ready` is 1. With block averaging disabled and `cfg_mov_code` = 00, every accepted beat appears on the outputs one clock later, with `m_valid` high.
- R2: While `m_valid` is 1 and `m_ready` is 0, `s_ready` is 0, no input is taken, and `m_cha`/`m_chb` hold their values. When `m_ready` rises, a waiting input beat is accepted in that same cycle.
- R3: With `cfg_pair_avg` = 1, both channels carry floor((A + B + 1) / 2) computed on the signed values. This happens before any time averaging.
- R4: With `cfg_blk_en` = 1, a code of `cfg_blk_code` from 0 to 6 selects a block of N = 2^(code+1) accepted beats, and code 7 selects N = 128. Only the N-th beat of a block produces an output. Its value is floor((sum + N/2) / N) for each channel.
- R5: When `cfg_blk_en` = 1, block averaging is used whatever the value of `cfg_mov_code`.
- R6: A high `cfg_blk_sync` clears the block accumulation. A beat accepted in the same cycle is discarded and produces no output. The next accepted beat starts a new block. Disabling block averaging also clears the block accumulation.
- R7: With `cfg_blk_en` = 0, moving codes 01, 10 and 11 select windows of L = 2, 4 and 8 beats. Starting from the L-th accepted beat, every beat produces an output equal to floor((sum of the last L beats + L/2) / L).
- R8: A change of `cfg_mov_code` or `cfg_blk_en` empties the moving window. A beat accepted in the cycle of the change is the first beat of the new window.
- R9: With `cfg_offset_bin` = 1, output bit 19 is inverted, which gives offset binary. With 0, the output stays in two's complement.
- R10: When `cfg_xor_sel` = 01111, output bits 19..1 are each XORed with output bit 0 after format conversion, and bit 0 is unchanged. Any other value applies no XOR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_blk_en | input | 1 | Enable block (decimating) averaging |
| cfg_blk_code | input | 3 | Block length code, N = 2^(code+1), capped at 128 |
| cfg_blk_sync | input | 1 | One-cycle pulse that restarts block accumulation |
| cfg_mov_code | input | 2 | Moving window code: 00 off, 01/10/11 for 2/4/8 beats |
| cfg_pair_avg | input | 1 | Replace both channels by their rounded mean |
| cfg_offset_bin | input | 1 | 1 = offset binary output, 0 = two's complement |
| cfg_xor_sel | input | 5 | 01111 enables the LSB-keyed XOR scramble |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat can be accepted |
| s_cha | input | 20 | Channel A sample, signed |
| s_chb | input | 20 | Channel B sample, signed |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream can take the output beat |
| m_cha | output | 20 | Channel A result |
| m_chb | output | 20 | Channel B result |

## Verification
The case that is hardest to reach from the ports is a boundary between accumulation states. One example is a sync pulse that lands in the same cycle as an accepted beat: that beat must vanish, and the block must restart on the following beat. Another is a moving-window code change that coincides with a beat, which must seed the new window. The stimulus times `cfg_blk_sync` and `cfg_mov_code` edges to the exact negative edge on which the bench drives a beat. It then checks that no output appears until a fresh block or window completes, and that the completing value averages only the post-change beats. Every block length, including the capped code 7 with its 128-beat block, is swept with signed extremes mixed in, so that the rounding offset and the widest accumulator value are both exercised.

// File: rtl/samp_cond_pkg.sv
package samp_cond_pkg;

  typedef enum logic [1:0] {
    PATH_PASS  = 2'd0,
    PATH_BLOCK = 2'd1,
    PATH_MOVE  = 2'd2
  } path_e;

  localparam logic [4:0] XOR_KEY = 5'b01111;

endpackage

// File: rtl/pair_mean.sv
module pair_mean #(
  parameter int W = 20
) (
  input  logic                en,
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] oa,
  output logic signed [W-1:0] ob
);
  localparam int SW = W + 1;

  logic signed [SW-1:0] total;
  logic signed [SW-1:0] half;

  always_comb begin
    total = SW'(a) + SW'(b) + SW'(1);
    half  = total >>> 1;
    oa    = en ? W'(half) : a;
    ob    = en ? W'(half) : b;
  end

endmodule

// File: rtl/blk_avg_lane.sv
module blk_avg_lane #(
  parameter int W       = 20,
  parameter int MAXLOG  = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic                clear,
  input  logic [2:0]          code,
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] dout,
  output logic                done
);
  localparam int ACC_W = W + MAXLOG;
  localparam int RW    = ACC_W + 1;
  localparam int CNT_W = MAXLOG;

  logic signed [ACC_W-1:0] acc, acc_sum;
  logic [CNT_W-1:0]        cnt, last_idx;
  logic [2:0]              k;
  logic signed [RW-1:0]    rnd, avg;
  logic                    at_end;

  always_comb begin
    k        = (int'(code) >= MAXLOG - 1) ? 3'(MAXLOG) : code + 3'd1;
    last_idx = CNT_W'((1 << k) - 1);
    acc_sum  = acc + ACC_W'(din);
    at_end   = (cnt >= last_idx);
    done     = step && !clear && at_end;
    rnd      = RW'(acc_sum) + (RW'(1) << (k - 3'd1));
    avg      = rnd >>> k;
    dout     = W'(avg);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
      cnt <= '0;
    end else if (clear) begin
      acc <= '0;
      cnt <= '0;
    end else if (step) begin
      if (at_end) begin
        acc <= '0;
        cnt <= '0;
      end else begin
        acc <= acc_sum;
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R4
  blk_done_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  blk_sync_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0));

endmodule

// File: rtl/mov_avg_lane.sv
module mov_avg_lane #(
  parameter int W         = 20,
  parameter int DEPTH_LOG = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic                clear,
  input  logic [1:0]          code,
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] dout,
  output logic                done
);
  localparam int DEPTH  = 1 << DEPTH_LOG;
  localparam int SUM_W  = W + DEPTH_LOG;
  localparam int RW     = SUM_W + 1;
  localparam int FILL_W = DEPTH_LOG + 1;

  logic signed [W-1:0]     hist [DEPTH];
  logic signed [SUM_W-1:0] sum, base_sum, sum_next;
  logic [FILL_W-1:0]       fill, base_fill, wlen;
  logic [DEPTH_LOG-1:0]    oldest;
  logic signed [W-1:0]     drop;
  logic signed [RW-1:0]    half, rnd, avg;

  always_comb begin
    wlen      = FILL_W'(1) << code;
    oldest    = DEPTH_LOG'(wlen - 1'b1);
    base_sum  = clear ? '0 : sum;
    base_fill = clear ? '0 : fill;
    drop      = (base_fill >= wlen) ? hist[oldest] : '0;
    sum_next  = base_sum + SUM_W'(din) - SUM_W'(drop);
    done      = step && (code != 2'd0) && (base_fill >= wlen - 1'b1);
    half      = (code == 2'd0) ? '0 : (RW'(1) << (code - 2'd1));
    rnd       = RW'(sum_next) + half;
    avg       = rnd >>> code;
    dout      = W'(avg);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum  <= '0;
      fill <= '0;
      for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
    end else if (step) begin
      hist[0] <= din;
      for (int i = 1; i < DEPTH; i++) hist[i] <= hist[i-1];
      sum  <= sum_next;
      fill <= (base_fill == FILL_W'(DEPTH)) ? base_fill : base_fill + 1'b1;
    end else if (clear) begin
      sum  <= '0;
      fill <= '0;
    end
  end

  // R7
  mov_fill_after_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (fill >= $past(wlen)));

  // R8
  mov_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && step) |=> (fill == FILL_W'(1)));

endmodule

// File: rtl/out_coder.sv
module out_coder
  import samp_cond_pkg::*;
#(
  parameter int W = 20
) (
  input  logic         offset_bin,
  input  logic [4:0]   xor_sel,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] fmt;

  always_comb begin
    fmt = din;
    if (offset_bin) fmt[W-1] = ~din[W-1];
    dout = fmt;
    if (xor_sel == XOR_KEY) dout[W-1:1] = fmt[W-1:1] ^ {(W-1){fmt[0]}};
  end

endmodule

// File: rtl/samp_cond.sv
module samp_cond
  import samp_cond_pkg::*;
#(
  parameter int SAMPLE_W      = 20,
  parameter int MAX_BLK_LOG   = 7,
  parameter int MOV_DEPTH_LOG = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_blk_en,
  input  logic [2:0]          cfg_blk_code,
  input  logic                cfg_blk_sync,
  input  logic [1:0]          cfg_mov_code,
  input  logic                cfg_pair_avg,
  input  logic                cfg_offset_bin,
  input  logic [4:0]          cfg_xor_sel,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_cha,
  input  logic [SAMPLE_W-1:0] s_chb,
  output logic                m_valid,
  input  logic                m_ready,
  output logic [SAMPLE_W-1:0] m_cha,
  output logic [SAMPLE_W-1:0] m_chb
);
  localparam int NCH = 2;

  logic  accept, blk_act, mov_act, mov_clear, blk_clear, produce;
  logic  blk_en_q;
  logic [1:0] mov_code_q;
  path_e path;

  logic signed [SAMPLE_W-1:0] lane_in  [NCH];
  logic signed [SAMPLE_W-1:0] blk_out  [NCH];
  logic signed [SAMPLE_W-1:0] mov_out  [NCH];
  logic signed [SAMPLE_W-1:0] staged   [NCH];
  logic [SAMPLE_W-1:0]        coded    [NCH];
  logic [NCH-1:0]             blk_done, mov_done;

  assign s_ready = !m_valid || m_ready;
  assign accept  = s_valid && s_ready;

  always_comb begin
    blk_act   = cfg_blk_en;
    mov_act   = !cfg_blk_en && (cfg_mov_code != 2'd0);
    blk_clear = cfg_blk_sync || !cfg_blk_en;
    mov_clear = !mov_act || (cfg_mov_code != mov_code_q) || (cfg_blk_en != blk_en_q);
    if (blk_act)      path = PATH_BLOCK;
    else if (mov_act) path = PATH_MOVE;
    else              path = PATH_PASS;
    case (path)
      PATH_BLOCK: produce = blk_done[0];
      PATH_MOVE:  produce = mov_done[0];
      default:    produce = accept;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_en_q   <= 1'b0;
      mov_code_q <= 2'd0;
    end else begin
      blk_en_q   <= cfg_blk_en;
      mov_code_q <= cfg_mov_code;
    end
  end

  pair_mean #(.W(SAMPLE_W)) u_pair (
    .en (cfg_pair_avg),
    .a  (s_cha),
    .b  (s_chb),
    .oa (lane_in[0]),
    .ob (lane_in[1])
  );

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    blk_avg_lane #(.W(SAMPLE_W), .MAXLOG(MAX_BLK_LOG)) u_blk (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (accept && blk_act),
      .clear (blk_clear),
      .code  (cfg_blk_code),
      .din   (lane_in[g]),
      .dout  (blk_out[g]),
      .done  (blk_done[g])
    );

    mov_avg_lane #(.W(SAMPLE_W), .DEPTH_LOG(MOV_DEPTH_LOG)) u_mov (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (accept && mov_act),
      .clear (mov_clear),
      .code  (cfg_mov_code),
      .din   (lane_in[g]),
      .dout  (mov_out[g]),
      .done  (mov_done[g])
    );

    always_comb begin
      case (path)
        PATH_BLOCK: staged[g] = blk_out[g];
        PATH_MOVE:  staged[g] = mov_out[g];
        default:    staged[g] = lane_in[g];
      endcase
    end

    out_coder #(.W(SAMPLE_W)) u_cod (
      .offset_bin (cfg_offset_bin),
      .xor_sel    (cfg_xor_sel),
      .din        (staged[g]),
      .dout       (coded[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_cha   <= '0;
      m_chb   <= '0;
    end else if (produce) begin
      m_valid <= 1'b1;
      m_cha   <= coded[0];
      m_chb   <= coded[1];
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_cha) && $stable(m_chb)));

  // R2
  stall_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !s_ready);

  // R1
  pass_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && path == PATH_PASS) |=> m_valid);

  // R4
  lane_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_done[0] == blk_done[1]) && (mov_done[0] == mov_done[1]));

endmodule

// File: tb/samp_cond_bench.sv
module samp_cond_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_blk_en = 0, cfg_blk_sync = 0, cfg_pair_avg = 0, cfg_offset_bin = 0;
  logic [2:0] cfg_blk_code = 0;
  logic [1:0] cfg_mov_code = 0;
  logic [4:0] cfg_xor_sel = 0;
  logic s_valid = 0, m_ready = 1;
  logic [19:0] s_cha = 0, s_chb = 0;
  logic s_ready, m_valid;
  logic [19:0] m_cha, m_chb;

  int n_chk = 0, n_err = 0;
  bit done_flag = 0;
  logic got_v;
  logic [19:0] got_a, got_b;
  int hist_a [200];
  int hist_b [200];

  always #2 clk = ~clk;

  samp_cond u_samp_cond (
    .clk(clk), .rst_n(rst_n), .cfg_blk_en(cfg_blk_en), .cfg_blk_code(cfg_blk_code),
    .cfg_blk_sync(cfg_blk_sync), .cfg_mov_code(cfg_mov_code), .cfg_pair_avg(cfg_pair_avg),
    .cfg_offset_bin(cfg_offset_bin), .cfg_xor_sel(cfg_xor_sel), .s_valid(s_valid),
    .s_ready(s_ready), .s_cha(s_cha), .s_chb(s_chb), .m_valid(m_valid),
    .m_ready(m_ready), .m_cha(m_cha), .m_chb(m_chb)
  );

  task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] enc(input int v, input bit fmt, input logic [4:0] xs);
    logic [19:0] w;
    w = v[19:0];
    if (fmt) w[19] = ~w[19];
    if (xs == 5'b01111) w[19:1] = w[19:1] ^ {19{w[0]}};
    return w;
  endfunction

  function automatic int rnd(input longint s, input int k);
    return int'((s + (longint'(1) <<< (k - 1))) >>> k);
  endfunction

  function automatic int pat_a(input int i);
    if (i % 5 == 0) return 524287;
    return ((i * 40503) % 1000000) - 500000;
  endfunction

  function automatic int pat_b(input int i);
    if (i % 7 == 3) return -524288;
    return 480000 - ((i * 71317) % 960000);
  endfunction

  task automatic cfg(input bit be, input logic [2:0] bc, input logic [1:0] mc,
                     input bit pa, input bit fm, input logic [4:0] xs);
    @(negedge clk);
    cfg_blk_en = be; cfg_blk_code = bc; cfg_mov_code = mc;
    cfg_pair_avg = pa; cfg_offset_bin = fm; cfg_xor_sel = xs;
  endtask

  task automatic push(input int a, input int b, input bit sync);
    @(negedge clk);
    s_valid = 1; s_cha = a[19:0]; s_chb = b[19:0]; cfg_blk_sync = sync;
    @(negedge clk);
    s_valid = 0; cfg_blk_sync = 0;
    got_v = m_valid; got_a = m_cha; got_b = m_chb;
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int vals [8];
    int k, n, L;
    longint sa, sb;
    bit early;
    vals = '{0, 1, -1, 524287, -524288, 174762, -87381, 3};

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset m_valid", 20'(m_valid), 20'(0));
    chk("R1 reset s_ready", 20'(s_ready), 20'(1));
    rst_n = 1;

    // R1 R9 R10 pass-through sweep over format and xor selections
    for (int f = 0; f < 2; f++) begin
      for (int x = 0; x < 4; x++) begin
        logic [4:0] xs;
        xs = (x == 0) ? 5'b00000 : (x == 1) ? 5'b01111 : (x == 2) ? 5'b11111 : 5'b00001;
        cfg(0, 0, 0, 0, f[0], xs);
        for (int i = 0; i < 8; i++) begin
          push(vals[i], vals[7 - i], 0);
          chk("R1 pass valid", 20'(got_v), 20'(1));
          chk("R9 R10 pass cha", got_a, enc(vals[i], f[0], xs));
          chk("R9 R10 pass chb", got_b, enc(vals[7 - i], f[0], xs));
        end
      end
    end

    // R3 pair mean
    cfg(0, 0, 0, 1, 0, 0);
    for (int i = 0; i < 8; i++) begin
      int e;
      e = (vals[i] + vals[(i + 3) % 8] + 1) >>> 1;
      push(vals[i], vals[(i + 3) % 8], 0);
      chk("R3 pair cha", got_a, e[19:0]);
      chk("R3 pair chb", got_b, e[19:0]);
    end

    // R4 block lengths, all codes including capped code 7
    for (int c = 0; c < 8; c++) begin
      k = (c >= 6) ? 7 : c + 1;
      n = 1 << k;
      cfg(1, c[2:0], 0, 0, 0, 0);
      sa = 0; sb = 0; early = 0;
      for (int i = 0; i < n; i++) begin
        push(pat_a(i + c), pat_b(i + c), 0);
        sa += pat_a(i + c); sb += pat_b(i + c);
        if (i < n - 1 && got_v) early = 1;
      end
      chk("R4 no early output", 20'(early), 20'(0));
      chk("R4 block valid", 20'(got_v), 20'(1));
      chk("R4 block cha", got_a, 20'(rnd(sa, k)));
      chk("R4 block chb", got_b, 20'(rnd(sb, k)));
    end

    // R3 R4 pair mean feeding block average, coded
    cfg(1, 3'd1, 0, 1, 1, 5'b01111);
    sa = 0;
    for (int i = 0; i < 4; i++) begin
      push(pat_a(i), pat_b(i), 0);
      sa += (pat_a(i) + pat_b(i) + 1) >>> 1;
    end
    chk("R3 R4 pair block cha", got_a, enc(rnd(sa, 2), 1, 5'b01111));

    // R6 sync with a beat in the same cycle
    cfg(1, 3'd1, 0, 0, 0, 0);
    push(300000, -300000, 0);
    push(300000, -300000, 0);
    push(500000, 500000, 1);
    chk("R6 sync beat dropped", 20'(got_v), 20'(0));
    sa = 0; sb = 0; early = 0;
    for (int i = 0; i < 4; i++) begin
      push(i * 1000 + 7, -i * 333, 0);
      sa += i * 1000 + 7; sb += -i * 333;
      if (i < 3 && got_v) early = 1;
    end
    chk("R6 no early after sync", 20'(early), 20'(0));
    chk("R6 new block cha", got_a, 20'(rnd(sa, 2)));
    chk("R6 new block chb", got_b, 20'(rnd(sb, 2)));

    // R5 block wins over moving
    cfg(1, 3'd0, 2'd3, 0, 0, 0);
    push(11, 20, 0);
    chk("R5 first beat no output", 20'(got_v), 20'(0));
    push(14, -9, 0);
    chk("R5 block valid", 20'(got_v), 20'(1));
    chk("R5 block cha", got_a, 20'(rnd(25, 1)));
    chk("R5 block chb", got_b, 20'(rnd(11, 1)));

    // R7 moving windows
    for (int c = 1; c < 4; c++) begin
      L = 1 << c;
      cfg(0, 0, c[1:0], 0, 0, 0);
      for (int i = 0; i < 12; i++) begin
        hist_a[i] = pat_a(i * 3 + c);
        hist_b[i] = pat_b(i * 5 + c);
        push(hist_a[i], hist_b[i], 0);
        if (i < L - 1) begin
          chk("R7 window filling", 20'(got_v), 20'(0));
        end else begin
          sa = 0; sb = 0;
          for (int j = i - L + 1; j <= i; j++) begin
            sa += hist_a[j]; sb += hist_b[j];
          end
          chk("R7 moving valid", 20'(got_v), 20'(1));
          chk("R7 moving cha", got_a, 20'(rnd(sa, c)));
          chk("R7 moving chb", got_b, 20'(rnd(sb, c)));
        end
      end
    end

    // R8 code change coinciding with a beat seeds the new window
    cfg(0, 0, 2'd2, 0, 0, 0);
    for (int i = 0; i < 5; i++) push(90000 + i, 1000, 0);
    @(negedge clk);
    cfg_mov_code = 2'd1;
    s_valid = 1; s_cha = 20'(-40001); s_chb = 20'(5);
    @(negedge clk);
    s_valid = 0;
    chk("R8 first beat of new window", 20'(m_valid), 20'(0));
    push(-20000, 8, 0);
    chk("R8 new window valid", 20'(got_v), 20'(1));
    chk("R8 new window cha", got_a, 20'(rnd(-60001, 1)));
    chk("R8 new window chb", got_b, 20'(rnd(13, 1)));

    // R2 back-pressure
    cfg(0, 0, 0, 0, 0, 0);
    @(negedge clk);
    m_ready = 0; s_valid = 1; s_cha = 20'd1234; s_chb = 20'd4321;
    @(negedge clk);
    s_cha = 20'd777; s_chb = 20'd888;
    chk("R2 stalled valid", 20'(m_valid), 20'(1));
    chk("R2 stalled ready low", 20'(s_ready), 20'(0));
    repeat (3) @(negedge clk);
    chk("R2 held cha", m_cha, 20'd1234);
    chk("R2 held chb", m_chb, 20'd4321);
    chk("R2 still blocked", 20'(s_ready), 20'(0));
    m_ready = 1;
    @(negedge clk);
    s_valid = 0;
    chk("R2 waiting beat taken", m_cha, 20'd777);
    @(negedge clk);
    chk("R2 drained", 20'(m_valid), 20'(0));

    finish_run();
  end

endmodule